// File: doc/BRIEF.md
# Bridge Fault Protection Controller

This block supervises a two-channel H-bridge output stage. It watches synchronous flags for over-current, over-voltage and supply under-voltage, together with a digital die-temperature code in degrees Celsius. From these and two control pins, a power enable and a tri-state request, it produces a single enable for the bridge drivers, an active-low fault status and an active-low early thermal warning.

The fault condition is the OR of over-current, over-voltage and a hysteretic over-temperature trip. A fault is latched, and while it is latched the bridges are held in high impedance. A build parameter selects how the latch is released. In latched mode, the tri-state pin must go low and then high again once the cause has gone. In retry mode, a cycle counter stands in for an external RC timer. The latch is released when the count expires and is set again at once if any cause is still present. Under-voltage only blocks the drive and releases it by itself. It never sets the fault latch.

Top module: `bridge_guard`

## Requirements
- R1: While rst_n is low, drv_en is 0, fault_n is 1 and warn_n is 1, whatever the inputs. After reset, drv_en rises at the first clock edge that samples pwr_on=1, tri_in=1, uv_flag=0 and no fault.
- R2: A clock edge that samples oc_flag=1 or ov_flag=1 drives fault_n to 0 and drv_en to 0 at that same edge.
- R3: temp_code is read in degrees Celsius. An edge that samples a value of at least 150 trips the thermal condition, which counts as a fault. The trip stays active while temp_code is above 125 and clears at the first edge that samples 125 or less. A value of 149 never trips it.
- R4: warn_n is 0 after every edge that samples temp_code of 130 or more, and 1 after every edge that samples less than 130. This is independent of the fault latch.
- R5: An edge that samples uv_flag=1 drives drv_en to 0 and leaves fault_n unchanged. The first edge that samples uv_flag=0, with the other enable conditions met, restores drv_en=1.
- R6: An edge that samples pwr_on=0 or tri_in=0 drives drv_en to 0.
- R7: Latched mode (AUTO_RETRY=0): fault_n stays 0 after the causes have gone. The latch clears at the first edge that samples tri_in=1 after an edge that sampled a high-to-low change of tri_in while the latch was set. drv_en returns at that same edge.
- R8: Latched mode: a low-then-high tri_in pulse completed while a cause is still present does not clear the latch, and it is used up. A new pulse is needed after the cause has gone. A tri_in low with no fault latched arms nothing.
- R9: Retry mode (AUTO_RETRY=1): after a one-cycle cause, fault_n is 0 for exactly RETRY_CYCLES clock cycles and then returns to 1. tri_in pulses do not shorten this window.
- R10: Retry mode: while a cause persists, fault_n stays 0 across every count expiry. After the cause is removed, fault_n returns to 1 within RETRY_CYCLES edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| oc_flag | input | 1 | Over-current flag, synchronous |
| ov_flag | input | 1 | Over-voltage flag, synchronous |
| uv_flag | input | 1 | Supply under-voltage flag, synchronous |
| temp_code | input | TEMP_W | Die temperature in degrees Celsius |
| pwr_on | input | 1 | 0 shuts the bridges down, 1 allows operation |
| tri_in | input | 1 | 0 forces high impedance; low-high pulse clears a latched fault |
| drv_en | output | 1 | 1 lets the bridge drivers switch, 0 holds high impedance |
| fault_n | output | 1 | Fault status, active low |
| warn_n | output | 1 | Early thermal warning, active low |

## Verification
The bench builds two copies side by side. One uses AUTO_RETRY=0, which puts the tri-state release sequence, its consumption under a live fault and the thermal hysteresis band within reach of a table of vectors. The other uses AUTO_RETRY=1 with RETRY_CYCLES=8, so the exact length of a retry window and its restart under a persisting cause can be counted edge by edge. The default count of 4096 would make both of these impractical to walk.

// File: rtl/bridge_guard.sv
module bridge_guard #(
  parameter bit AUTO_RETRY   = 1'b0,
  parameter int RETRY_CYCLES = 4096,
  parameter int TEMP_W       = 8,
  parameter int WARN_CODE    = 130,
  parameter int TRIP_CODE    = 150,
  parameter int HYST         = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              oc_flag,
  input  logic              ov_flag,
  input  logic              uv_flag,
  input  logic [TEMP_W-1:0] temp_code,
  input  logic              pwr_on,
  input  logic              tri_in,
  output logic              drv_en,
  output logic              fault_n,
  output logic              warn_n
);
  localparam int CNT_W = (RETRY_CYCLES > 2) ? $clog2(RETRY_CYCLES) : 1;
  localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(RETRY_CYCLES - 1);
  localparam logic [TEMP_W-1:0] WARN_T   = TEMP_W'(WARN_CODE);
  localparam logic [TEMP_W-1:0] TRIP_T   = TEMP_W'(TRIP_CODE);
  localparam logic [TEMP_W-1:0] CLEAR_T  = TEMP_W'(TRIP_CODE - HYST);

  logic therm_q, flt_q, en_q, warn_q;
  logic therm_hot, fault_raw, flt_next;

  assign therm_hot = (temp_code >= TRIP_T) | (therm_q & (temp_code > CLEAR_T));
  assign fault_raw = oc_flag | ov_flag | therm_hot;

  generate
    if (AUTO_RETRY) begin : g_retry
      logic [CNT_W-1:0] cnt_q;
      assign flt_next = flt_q ? ((cnt_q == CNT_LAST) ? fault_raw : 1'b1) : fault_raw;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        cnt_q <= '0;
        else if (!flt_q || cnt_q == CNT_LAST) cnt_q <= '0;
        else                               cnt_q <= cnt_q + 1'b1;
      end
    end else begin : g_latch
      logic tri_q, arm_q, clr;
      assign clr      = arm_q & tri_in;
      assign flt_next = fault_raw | (flt_q & ~clr);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          tri_q <= 1'b0;
          arm_q <= 1'b0;
        end else begin
          tri_q <= tri_in;
          if (!flt_q || clr)        arm_q <= 1'b0;
          else if (tri_q && !tri_in) arm_q <= 1'b1;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      therm_q <= 1'b0;
      flt_q   <= 1'b0;
      en_q    <= 1'b0;
      warn_q  <= 1'b0;
    end else begin
      therm_q <= therm_hot;
      flt_q   <= flt_next;
      en_q    <= pwr_on & tri_in & ~uv_flag & ~flt_next;
      warn_q  <= temp_code >= WARN_T;
    end
  end

  assign drv_en  = en_q;
  assign fault_n = ~flt_q;
  assign warn_n  = ~warn_q;
endmodule

// File: rtl/bridge_guard_chk.sv
module bridge_guard_chk #(
  parameter int TEMP_W    = 8,
  parameter int WARN_CODE = 130,
  parameter int TRIP_CODE = 150
) (
  input logic              clk,
  input logic              rst_n,
  input logic              oc_flag,
  input logic              ov_flag,
  input logic              uv_flag,
  input logic [TEMP_W-1:0] temp_code,
  input logic              pwr_on,
  input logic              tri_in,
  input logic              drv_en,
  input logic              fault_n,
  input logic              warn_n
);
  // R2
  trip_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_flag || ov_flag) |=> (!fault_n && !drv_en));

  // R3
  hot_die_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_code >= TEMP_W'(TRIP_CODE)) |=> !fault_n);

  // R4
  warn_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_code >= TEMP_W'(WARN_CODE)) |=> !warn_n);

  // R4
  warn_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_code < TEMP_W'(WARN_CODE)) |=> warn_n);

  // R5
  uv_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uv_flag |=> !drv_en);

  // R6
  pin_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_on || !tri_in) |=> !drv_en);

  // R7
  fault_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_n |-> !drv_en);
endmodule

bind bridge_guard bridge_guard_chk #(
  .TEMP_W(TEMP_W), .WARN_CODE(WARN_CODE), .TRIP_CODE(TRIP_CODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .oc_flag(oc_flag), .ov_flag(ov_flag),
  .uv_flag(uv_flag), .temp_code(temp_code), .pwr_on(pwr_on), .tri_in(tri_in),
  .drv_en(drv_en), .fault_n(fault_n), .warn_n(warn_n)
);

// File: tb/bridge_guard_tb.sv
module bridge_guard_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic oc = 0, ov = 0, uv = 0, pw = 0, tri_p = 0;
  logic [7:0] temp = 8'd25;
  logic en, fn, wn;
  logic a_oc = 0, a_ov = 0, a_tri = 1;
  logic a_en, a_fn, a_wn;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  bridge_guard #(.AUTO_RETRY(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .oc_flag(oc), .ov_flag(ov), .uv_flag(uv),
    .temp_code(temp), .pwr_on(pw), .tri_in(tri_p),
    .drv_en(en), .fault_n(fn), .warn_n(wn));

  bridge_guard #(.AUTO_RETRY(1'b1), .RETRY_CYCLES(8)) u_auto (
    .clk(clk), .rst_n(rst_n), .oc_flag(a_oc), .ov_flag(a_ov), .uv_flag(1'b0),
    .temp_code(8'd25), .pwr_on(1'b1), .tri_in(a_tri),
    .drv_en(a_en), .fault_n(a_fn), .warn_n(a_wn));

  // oc ov uv pw tri | temp | exp en fn wn
  localparam logic [15:0] VEC [21] = '{
    16'b0_0_0_1_1_00011001_1_1_1, // R1 enable after reset
    16'b1_0_0_1_1_00011001_0_0_1, // R2 over-current
    16'b0_0_0_1_1_00011001_0_0_1, // R7 held
    16'b0_0_0_1_0_00011001_0_0_1, // R7 tri low
    16'b0_0_0_1_1_00011001_1_1_1, // R7 tri high clears
    16'b0_0_0_1_1_10000111_1_1_0, // R4 warn at 135
    16'b0_0_0_1_1_10010110_0_0_0, // R3 trip at 150
    16'b0_0_0_1_1_10001100_0_0_0, // R3 held at 140
    16'b0_0_0_1_0_01111110_0_0_1, // R3 126 still hot
    16'b0_0_0_1_1_01111110_0_0_1, // R8 pulse under live fault
    16'b0_0_0_1_1_01111101_0_0_1, // R8 cause gone, pulse used up
    16'b0_0_0_1_0_01111101_0_0_1, // R8 new pulse low
    16'b0_0_0_1_1_01111101_1_1_1, // R7 clear
    16'b0_0_1_1_1_00011001_0_1_1, // R5 uv
    16'b0_0_0_1_1_00011001_1_1_1, // R5 recover
    16'b0_0_0_0_1_00011001_0_1_1, // R6 power down
    16'b0_0_0_1_0_00011001_0_1_1, // R6 tri low, R8 arms nothing
    16'b0_1_0_1_1_00011001_0_0_1, // R2 over-voltage
    16'b0_0_0_1_1_10000001_0_0_1, // R4 129 no warn
    16'b0_0_0_1_0_10000010_0_0_0, // R4 130 warns
    16'b0_0_0_1_1_10010101_1_1_0  // R7 clear, R3 149 no trip
  };

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s en/fn/wn actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk1(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    pw = 1; tri_p = 1; temp = 8'd200; oc = 1;
    repeat (3) @(posedge clk);
    #1 chk("R1 reset", {en, fn, wn}, 3'b011);
    chk1("R1 reset auto", a_fn, 1'b1);
    @(negedge clk); oc = 0; temp = 8'd25; pw = 0; rst_n = 1;
    @(posedge clk); #1 chk("R1 pw low", {en, fn, wn}, 3'b011);

    for (int i = 0; i < 21; i++) begin
      @(negedge clk);
      {oc, ov, uv, pw, tri_p, temp} = VEC[i][15:3];
      @(posedge clk); #1;
      chk($sformatf("vector %0d", i), {en, fn, wn}, VEC[i][2:0]);
    end

    // R9: one-cycle cause, exact window, tri pulse inside
    @(negedge clk); a_oc = 1;
    @(posedge clk); #1 chk1("R9 set", a_fn, 1'b0);
    @(negedge clk); a_oc = 0;
    for (int k = 1; k < 8; k++) begin
      if (k == 2) a_tri = 0;
      if (k == 3) a_tri = 1;
      @(posedge clk); #1 chk1($sformatf("R9 window cycle %0d", k), a_fn, 1'b0);
      @(negedge clk);
    end
    @(posedge clk); #1 chk1("R9 release", a_fn, 1'b1);
    chk1("R9 drive back", a_en, 1'b1);

    // R10: persisting cause
    @(negedge clk); a_ov = 1;
    for (int k = 0; k < 20; k++) begin
      @(posedge clk); #1 chk1($sformatf("R10 held %0d", k), a_fn, 1'b0);
      @(negedge clk);
    end
    a_ov = 0;
    begin
      int n = 0;
      for (int k = 0; k < 10; k++) begin
        @(posedge clk); #1 n++;
        if (a_fn) break;
        @(negedge clk);
      end
      total++;
      if (!a_fn || n > 8) begin
        bad++;
        $display("FAIL R10 release edges actual=%0d expected<=8", n);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule